// File: doc/BRIEF.md
# Ring cell token distribution controller

This block is the control section of one cell in a circular buffer whose cells share a common put bus and a common get bus. Two tokens travel around the ring. The cell that holds the put token is the one that takes the next word from the sender. The cell that holds the get token is the one that presents its stored word to the receiver. Stored data never moves between cells. The controller accepts tokens from its right neighbour and hands each token to the matching port controller. It forwards a token to its left neighbour only after the operation that token allowed has finished. It also produces the write enable and the read-bus enable for the cell's data register. That register and the wiring of the ring are not part of this block.

All channels use four-phase request/acknowledge handshakes. The block samples every handshake wire with the clock. One incoming channel carries both tokens in strict alternation. After reset the first token to arrive is treated as the put token, unless the parameter `FIRST_PUT` selects the get token instead. The cell requests the next token on its right channel. It acknowledges its left neighbour's request for a token. It serves the put and get ports passively, and it ignores a port request that arrives while the cell does not hold that port's token.

Top module: `ring_cell_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, every output is low: right_req, left_ack, put_ack, get_ack, reg_wr_en and bus_rd_en.
- R2: After reset the cell raises right_req. It lowers right_req only after right_ack has been high. A token counts as received when right_ack has then returned low.
- R3: With `FIRST_PUT` = 1, the first token received after reset is the put token. A put request is then served, and a get request is not served.
- R4: put_ack rises only while both put_req and the put token are present. A put_req that is raised while the cell has no put token leaves put_ack and reg_wr_en low.
- R5: Once put_ack is high, it stays high until put_req has fallen and the put token request has been withdrawn. The same holds for get_ack and get_req.
- R6: reg_wr_en is high for exactly one cycle in each put operation, in the cycle in which put_ack rises. It is never high during a get operation.
- R7: get_ack follows the same rules as put_ack, using get_req and the get token. bus_rd_en is high exactly in the cycles in which get_ack is high.
- R8: Tokens alternate put, get, put, get. In each token's turn, only the matching port can be acknowledged. put_ack and get_ack are never high together.
- R9: left_ack rises only when left_req is high and the current token's port operation has fully completed. A left_req raised before that point leaves left_ack low.
- R10: right_req does not rise again after a token is received until the left handshake for that token has completed and left_ack has fallen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| right_req | output | 1 | Request for a token from the right neighbour |
| right_ack | input | 1 | Right neighbour acknowledge (token handed over) |
| left_req | input | 1 | Left neighbour asks for the token |
| left_ack | output | 1 | Token handed to the left neighbour |
| put_req | input | 1 | Sender request on the shared put bus |
| put_ack | output | 1 | Put acknowledge from this cell |
| get_req | input | 1 | Receiver request on the shared get bus |
| get_ack | output | 1 | Get acknowledge from this cell |
| reg_wr_en | output | 1 | One-cycle write strobe for the cell data register |
| bus_rd_en | output | 1 | Drives the cell data register onto the get bus |

## Verification
The bench builds the block with its default `FIRST_PUT` = 1. With that value the opening token is a put token, so the first round checks that a get request is refused. The rounds that follow then alternate between put turns and get turns. Handshake delays come from a small pseudo-random generator. These delays push a port request, a left request and a token arrival into different orders. They also reach requests that arrive early and carry no token, and requests that are held after the acknowledge has risen. The write strobe and the read enable are both built into this configuration: a pulse for the put side and a level for the get side.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  typedef enum logic [2:0] {
    D_IDLE,
    D_RREQ,
    D_RREL,
    D_TOK,
    D_TREL,
    D_PASS,
    D_PREL
  } dist_st_e;

  typedef enum logic {
    TOK_PUT = 1'b0,
    TOK_GET = 1'b1
  } tok_kind_e;

endpackage

// File: rtl/rcc_tok_dist.sv
module rcc_tok_dist
  import rcc_pkg::*;
#(
  parameter bit FIRST_PUT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  output logic right_req,
  input  logic right_ack,
  output logic ptok_req,
  input  logic ptok_ack,
  output logic gtok_req,
  input  logic gtok_ack,
  output logic pass_req,
  input  logic pass_ack
);

  localparam tok_kind_e KIND_INIT = FIRST_PUT ? TOK_PUT : TOK_GET;

  dist_st_e  state_q, state_n;
  tok_kind_e kind_q;
  logic      sel_ack;

  assign sel_ack = (kind_q == TOK_PUT) ? ptok_ack : gtok_ack;

  always_comb begin
    state_n = state_q;
    case (state_q)
      D_IDLE:  state_n = D_RREQ;
      D_RREQ:  if (right_ack)  state_n = D_RREL;
      D_RREL:  if (!right_ack) state_n = D_TOK;
      D_TOK:   if (sel_ack)    state_n = D_TREL;
      D_TREL:  if (!sel_ack)   state_n = D_PASS;
      D_PASS:  if (pass_ack)   state_n = D_PREL;
      D_PREL:  if (!pass_ack)  state_n = D_RREQ;
      default: state_n = D_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= D_IDLE;
      kind_q    <= KIND_INIT;
      right_req <= 1'b0;
      ptok_req  <= 1'b0;
      gtok_req  <= 1'b0;
      pass_req  <= 1'b0;
    end else begin
      state_q   <= state_n;
      if (state_q == D_PREL && state_n == D_RREQ)
        kind_q <= (kind_q == TOK_PUT) ? TOK_GET : TOK_PUT;
      right_req <= (state_n == D_RREQ);
      ptok_req  <= (state_n == D_TOK) && (kind_q == TOK_PUT);
      gtok_req  <= (state_n == D_TOK) && (kind_q == TOK_GET);
      pass_req  <= (state_n == D_PASS);
    end
  end

endmodule

// File: rtl/rcc_port_join.sv
module rcc_port_join #(
  parameter bit EN_PULSE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic env_req,
  output logic env_ack,
  input  logic tok_req,
  output logic tok_ack,
  output logic reg_en
);

  logic ack_q, ack_n, fire;

  assign fire  = !ack_q && env_req && tok_req;
  assign ack_n = ack_q ? (env_req || tok_req) : fire;

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= ack_n;
  end

  generate
    if (EN_PULSE) begin : g_pulse
      logic en_q;
      always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= fire;
      end
      assign reg_en = en_q;
    end else begin : g_level
      logic en_q;
      always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= ack_n;
      end
      assign reg_en = en_q;
    end
  endgenerate

  assign env_ack = ack_q;
  assign tok_ack = ack_q;

endmodule

// File: rtl/rcc_left_join.sv
module rcc_left_join (
  input  logic clk,
  input  logic rst,
  input  logic left_req,
  output logic left_ack,
  input  logic pass_req,
  output logic pass_ack
);

  logic ack_q;

  always_ff @(posedge clk) begin
    if (rst)        ack_q <= 1'b0;
    else if (ack_q) ack_q <= left_req || pass_req;
    else            ack_q <= left_req && pass_req;
  end

  assign left_ack = ack_q;
  assign pass_ack = ack_q;

endmodule

// File: rtl/ring_cell_ctrl.sv
module ring_cell_ctrl #(
  parameter bit FIRST_PUT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  output logic right_req,
  input  logic right_ack,
  input  logic left_req,
  output logic left_ack,
  input  logic put_req,
  output logic put_ack,
  input  logic get_req,
  output logic get_ack,
  output logic reg_wr_en,
  output logic bus_rd_en
);

  logic ptok_r, ptok_a, gtok_r, gtok_a, pass_r, pass_a;

  rcc_tok_dist #(.FIRST_PUT(FIRST_PUT)) u_dist (
    .clk       (clk),
    .rst       (rst),
    .right_req (right_req),
    .right_ack (right_ack),
    .ptok_req  (ptok_r),
    .ptok_ack  (ptok_a),
    .gtok_req  (gtok_r),
    .gtok_ack  (gtok_a),
    .pass_req  (pass_r),
    .pass_ack  (pass_a)
  );

  rcc_port_join #(.EN_PULSE(1'b1)) u_put (
    .clk     (clk),
    .rst     (rst),
    .env_req (put_req),
    .env_ack (put_ack),
    .tok_req (ptok_r),
    .tok_ack (ptok_a),
    .reg_en  (reg_wr_en)
  );

  rcc_port_join #(.EN_PULSE(1'b0)) u_get (
    .clk     (clk),
    .rst     (rst),
    .env_req (get_req),
    .env_ack (get_ack),
    .tok_req (gtok_r),
    .tok_ack (gtok_a),
    .reg_en  (bus_rd_en)
  );

  rcc_left_join u_left (
    .clk      (clk),
    .rst      (rst),
    .left_req (left_req),
    .left_ack (left_ack),
    .pass_req (pass_r),
    .pass_ack (pass_a)
  );

endmodule

// File: rtl/ring_cell_ctrl_chk.sv
module ring_cell_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic right_req,
  input logic right_ack,
  input logic left_req,
  input logic left_ack,
  input logic put_req,
  input logic put_ack,
  input logic get_req,
  input logic get_ack,
  input logic reg_wr_en,
  input logic bus_rd_en,
  input logic ptok_r,
  input logic gtok_r,
  input logic pass_r,
  input logic pass_a
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !right_req && !left_ack && !put_ack && !get_ack && !reg_wr_en && !bus_rd_en);

  p_right_drop_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(right_req) |-> $past(right_ack));

  p_put_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(put_ack) |-> $past(put_req) && $past(ptok_r));

  p_put_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(put_ack) |-> !$past(put_req) && !$past(ptok_r));

  p_get_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(get_ack) |-> !$past(get_req) && !$past(gtok_r));

  p_wr_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(put_ack) |-> reg_wr_en);

  p_wr_single_r6: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en);

  p_get_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(get_ack) |-> $past(get_req) && $past(gtok_r) && bus_rd_en);

  p_rd_off_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(get_ack) |-> !bus_rd_en);

  p_one_port_r8: assert property (@(posedge clk) disable iff (rst)
    !(put_ack && get_ack) && !(ptok_r && gtok_r));

  p_left_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(left_ack) |-> $past(left_req) && $past(pass_r));

  p_rerequest_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(right_req) |-> !$past(pass_a) && !$past(left_ack));

endmodule

bind ring_cell_ctrl ring_cell_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .right_req (right_req),
  .right_ack (right_ack),
  .left_req  (left_req),
  .left_ack  (left_ack),
  .put_req   (put_req),
  .put_ack   (put_ack),
  .get_req   (get_req),
  .get_ack   (get_ack),
  .reg_wr_en (reg_wr_en),
  .bus_rd_en (bus_rd_en),
  .ptok_r    (ptok_r),
  .gtok_r    (gtok_r),
  .pass_r    (pass_r),
  .pass_a    (pass_a)
);

// File: tb/ring_cell_ctrl_tb.sv
module ring_cell_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 40;
  localparam int WATCHDOG   = 60000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic right_req, right_ack, left_req, left_ack;
  logic put_req, put_ack, get_req, get_ack, reg_wr_en, bus_rd_en;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit guard = 1'b0;
  int guard_viol = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_cell_ctrl u_dut (
    .clk(clk), .rst(rst),
    .right_req(right_req), .right_ack(right_ack),
    .left_req(left_req), .left_ack(left_ack),
    .put_req(put_req), .put_ack(put_ack),
    .get_req(get_req), .get_ack(get_ack),
    .reg_wr_en(reg_wr_en), .bus_rd_en(bus_rd_en)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG && !done) begin
      miscompares = miscompares + 1;
      $display("FAIL watchdog (all requirements): actual %0d expected %0d cycles", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  always @(negedge clk) if (guard && right_req) guard_viol = guard_viol + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors = vectors + 1;
    if (!ok) begin
      miscompares = miscompares + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rnd_delay();
    int n;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    n = int'(lfsr[1:0]);
    repeat (n) @(negedge clk);
  endtask

  task automatic right_hs();
    int t = 0;
    while (!right_req && t < TIMEOUT) begin @(negedge clk); t++; end
    check(right_req, "R2 right_req raised", int'(right_req), 1);
    rnd_delay();
    right_ack = 1'b1;
    t = 0;
    while (right_req && t < TIMEOUT) begin @(negedge clk); t++; end
    check(!right_req, "R2 right_req lowered after ack", int'(right_req), 0);
    rnd_delay();
    right_ack = 1'b0;
    @(negedge clk);
    guard = 1'b1;
    guard_viol = 0;
  endtask

  task automatic probe_port(input bit is_put, input string req);
    int seen = 0;
    int wr = 0;
    if (is_put) put_req = 1'b1; else get_req = 1'b1;
    repeat (6) begin
      @(negedge clk);
      seen += int'(is_put ? put_ack : get_ack);
      wr += int'(reg_wr_en);
    end
    put_req = 1'b0;
    get_req = 1'b0;
    repeat (2) begin
      @(negedge clk);
      seen += int'(is_put ? put_ack : get_ack);
    end
    check(seen == 0 && wr == 0, req, seen + wr, 0);
  endtask

  task automatic probe_left();
    int seen = 0;
    left_req = 1'b1;
    repeat (6) begin @(negedge clk); seen += int'(left_ack); end
    left_req = 1'b0;
    repeat (2) begin @(negedge clk); seen += int'(left_ack); end
    check(seen == 0, "R9 left_req before token done ignored", seen, 0);
  endtask

  task automatic port_op(input bit is_put);
    int t = 0;
    int wr = 0;
    int rd = 0;
    int rd_mis = 0;
    int other = 0;
    int drops = 0;
    bit acked = 1'b0;
    if (is_put) put_req = 1'b1; else get_req = 1'b1;
    while (t < TIMEOUT && !acked) begin
      @(negedge clk); t++;
      wr += int'(reg_wr_en); rd += int'(bus_rd_en);
      if (bus_rd_en != get_ack) rd_mis++;
      other += int'(is_put ? get_ack : put_ack);
      acked = is_put ? put_ack : get_ack;
    end
    check(acked, is_put ? "R4 put served with token" : "R7 get served with token", int'(acked), 1);
    repeat (4) begin
      @(negedge clk);
      wr += int'(reg_wr_en); rd += int'(bus_rd_en);
      if (bus_rd_en != get_ack) rd_mis++;
      if (!(is_put ? put_ack : get_ack)) drops++;
    end
    check(drops == 0, "R5 ack held while request high", drops, 0);
    put_req = 1'b0;
    get_req = 1'b0;
    t = 0;
    while (t < TIMEOUT && acked) begin
      @(negedge clk); t++;
      wr += int'(reg_wr_en); rd += int'(bus_rd_en);
      if (bus_rd_en != get_ack) rd_mis++;
      acked = is_put ? put_ack : get_ack;
    end
    check(!acked, "R5 ack released after request fell", int'(acked), 0);
    check(other == 0, "R8 other port not acknowledged", other, 0);
    if (is_put) begin
      check(wr == 1, "R6 write strobe one cycle per put", wr, 1);
    end else begin
      check(wr == 0, "R6 no write strobe during get", wr, 0);
      check(rd_mis == 0 && rd > 0, "R7 read enable tracks get_ack", rd_mis, 0);
    end
  endtask

  task automatic left_hs();
    int t = 0;
    rnd_delay();
    left_req = 1'b1;
    while (!left_ack && t < TIMEOUT) begin @(negedge clk); t++; end
    check(left_ack, "R9 token forwarded left", int'(left_ack), 1);
    rnd_delay();
    left_req = 1'b0;
    t = 0;
    while (left_ack && t < TIMEOUT) begin @(negedge clk); t++; end
    check(!left_ack, "R9 left_ack released", int'(left_ack), 0);
    guard = 1'b0;
    check(guard_viol == 0, "R10 no early right request", guard_viol, 0);
  endtask

  task automatic token_round(input bit is_put, input bit probes);
    right_hs();
    if (probes) begin
      probe_left();
      probe_port(!is_put, "R8 wrong-port request ignored");
    end
    rnd_delay();
    port_op(is_put);
    left_hs();
  endtask

  task automatic t_reset();
    int bad = 0;
    repeat (3) begin
      @(negedge clk);
      bad += int'(right_req) + int'(left_ack) + int'(put_ack) + int'(get_ack)
           + int'(reg_wr_en) + int'(bus_rd_en);
    end
    rst = 1'b0;
    @(posedge clk);
    #1;
    bad += int'(left_ack) + int'(put_ack) + int'(get_ack) + int'(reg_wr_en) + int'(bus_rd_en);
    check(bad == 0, "R1 outputs low in reset", bad, 0);
  endtask

  task automatic t_no_token();
    probe_port(1'b1, "R4 put without token ignored");
    probe_port(1'b0, "R7 get without token ignored");
    probe_left();
  endtask

  task automatic t_first_put();
    right_hs();
    probe_port(1'b0, "R3 first token refuses get");
    port_op(1'b1);
    left_hs();
  endtask

  task automatic t_get_turn();
    token_round(1'b0, 1'b1);
  endtask

  task automatic t_random_rounds();
    for (int i = 0; i < 30; i++) token_round(i[0] == 1'b0, i < 6);
  endtask

  initial begin
    right_ack = 1'b0;
    left_req  = 1'b0;
    put_req   = 1'b0;
    get_req   = 1'b0;
    t_reset();
    t_no_token();
    t_first_put();
    t_get_turn();
    t_random_rounds();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule